// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block governs data hazards in a five-stage in-order integer pipeline with 32 architectural registers. Every cycle it receives the register fields and control flags of the instruction in decode. It keeps its own shadow copy of the destination, write-enable and load flags for the execute, memory and writeback stages. From these it produces bypass selects for the two ALU operands in execute and for the two comparison operands of a branch that resolves in decode. It also produces a stall that holds the PC and the fetch/decode register, and a bubble that clears the execute-stage control bits so that an all-zero NOP goes down the pipe in place of the held instruction.

The pipeline keeps one architectural delay slot after every branch. The controller has no flush path: the instruction behind a branch always proceeds unless it has a data hazard of its own. An ALU result can be bypassed from the memory stage to execute and does not interlock ALU consumers. A load result exists only after the memory stage, so a dependent instruction directly behind a load waits one cycle. A branch comparing in decode waits one cycle behind a producing ALU instruction and two cycles behind a producing load. Register 0 always reads zero, so it takes no part in either mechanism.

The interlock keeps a small state machine. `S_RUN` means the previous cycle advanced normally. `S_LU_HOLD` means the previous cycle was held for a load-use hazard. `S_BR_HOLD` means the previous cycle was held for a branch operand. Every cycle the machine moves to `S_LU_HOLD` on a load-use hit (`T_TO_LU`), to `S_BR_HOLD` on a branch hit (`T_TO_BR`), and back to `S_RUN` otherwise (`T_TO_RUN`). The load-use hit takes priority over the branch hit.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: After reset, stall_o and bubble_o are 0, all four selects are 2'b00, and the shadow execute, memory and writeback stages hold NOPs, so nothing is bypassed from them.
- R2: An operand of the execute instruction whose register matches the destination of a writing, non-load memory-stage instruction gets select 2'b10.
- R3: An operand that matches only a writing writeback-stage instruction gets select 2'b01. With no match, or when the operand is unused, the select is 2'b00.
- R4: When the memory and writeback stages both write the operand's register, the memory stage (2'b10) wins.
- R5: Register 0 is never bypassed and never causes a stall, even when an older instruction names it as a written destination.
- R6: If a decode instruction uses a register that a load in execute writes, stall_o and bubble_o are asserted for exactly one cycle. The consumer then receives the loaded value from writeback (2'b01).
- R7: A load followed by an instruction that does not use its destination causes no stall.
- R8: During a stall, a NOP (no write, no load) enters execute, so the held decode instruction enters execute once only, and the bubble slot is never a bypass source.
- R9: A branch in decode (id_branch=1) whose operand is written by a non-load instruction in execute stalls one cycle. It then takes that operand from the memory stage (id_fwd select 2'b10).
- R10: A branch whose operand is written by a load stalls two cycles and then takes the operand from writeback (2'b01).
- R11: A branch never stalls or bubbles the instruction behind it (its delay slot) unless that instruction has its own data dependency.
- R12: A non-branch instruction that depends on an ALU result in execute does not stall. It is served later by bypassing.
- R13: id_fwd_a and id_fwd_b are 2'b00 whenever id_branch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_use_rs | input | 1 | The decode instruction reads id_rs |
| id_use_rt | input | 1 | The decode instruction reads id_rt |
| id_dst | input | 5 | Destination register of the decode instruction |
| id_wr | input | 1 | The decode instruction writes id_dst |
| id_load | input | 1 | The decode instruction is a load |
| id_branch | input | 1 | The decode instruction is a branch comparing in decode |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Clear the execute-stage control bits (insert NOP) |
| ex_fwd_a | output | 2 | ALU operand A select: 00 register, 01 writeback, 10 memory |
| ex_fwd_b | output | 2 | ALU operand B select, same encoding |
| id_fwd_a | output | 2 | Branch operand A select in decode, same encoding |
| id_fwd_b | output | 2 | Branch operand B select in decode, same encoding |

## Verification
The clash that matters is a stall and a bypass in the same cycle. While a load-use or branch interlock holds decode, the execute stage still carries an older instruction whose operands must be bypassed correctly. The cycle after the stall must then bypass the loaded value from writeback and not from the bubble. Directed sequences provoke this by placing an ALU producer, a load, and a dependent consumer or branch back to back. A random stream over only four registers then makes such overlaps frequent. A behavioural model of the pipe, with separate execute, memory and writeback slots, predicts every output each cycle. It judges the stall, the bubble and all four selects against that prediction.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Bypass source encoding shared by all operand selects
    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM  = 2'b10
    } fwd_sel_e;

    // Interlock state: what the previous cycle did
    typedef enum logic [1:0] {
        S_RUN     = 2'b00,
        S_LU_HOLD = 2'b01,
        S_BR_HOLD = 2'b10
    } lock_state_e;

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_wr,
    input  logic             id_load,
    output logic [REG_W-1:0] ex_rs,
    output logic [REG_W-1:0] ex_rt,
    output logic             ex_use_rs,
    output logic             ex_use_rt,
    output logic [REG_W-1:0] ex_dst,
    output logic             ex_wr,
    output logic             ex_load,
    output logic [REG_W-1:0] mem_dst,
    output logic             mem_wr,
    output logic             mem_load,
    output logic [REG_W-1:0] wb_dst,
    output logic             wb_wr
);

    // Execute slot: takes the decode instruction, or a NOP while held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_rs     <= '0;
            ex_rt     <= '0;
            ex_use_rs <= 1'b0;
            ex_use_rt <= 1'b0;
            ex_dst    <= '0;
            ex_wr     <= 1'b0;
            ex_load   <= 1'b0;
        end else if (hold) begin
            ex_rs     <= '0;
            ex_rt     <= '0;
            ex_use_rs <= 1'b0;
            ex_use_rt <= 1'b0;
            ex_dst    <= '0;
            ex_wr     <= 1'b0;
            ex_load   <= 1'b0;
        end else begin
            ex_rs     <= id_rs;
            ex_rt     <= id_rt;
            ex_use_rs <= id_use_rs;
            ex_use_rt <= id_use_rt;
            ex_dst    <= id_dst;
            ex_wr     <= id_wr;
            ex_load   <= id_load;
        end
    end

    // Memory and writeback slots advance every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_dst  <= '0;
            mem_wr   <= 1'b0;
            mem_load <= 1'b0;
            wb_dst   <= '0;
            wb_wr    <= 1'b0;
        end else begin
            mem_dst  <= ex_dst;
            mem_wr   <= ex_wr;
            mem_load <= ex_load;
            wb_dst   <= mem_dst;
            wb_wr    <= mem_wr;
        end
    end

    // R8
    hold_inserts_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!ex_wr && !ex_load && !ex_use_rs && !ex_use_rt));

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             used,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       sel
);

    logic live_src;
    logic hit_mem;
    logic hit_wb;

    assign live_src = used && (src != '0);
    assign hit_mem  = live_src && mem_wr && (mem_dst == src);
    assign hit_wb   = live_src && wb_wr && (wb_dst == src);

    // Younger producer first
    always_comb begin
        if (hit_mem)     sel = FWD_MEM;
        else if (hit_wb) sel = FWD_WB;
        else             sel = FWD_NONE;
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic             id_branch,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_load,
    output logic             stall_o,
    output logic             bubble_o
);

    lock_state_e state_q;
    lock_state_e state_d;

    logic ex_touch;
    logic mem_touch;
    logic lu_hit;
    logic br_ex_hit;
    logic br_mem_hit;

    // Does a decode source name a live destination?
    assign ex_touch  = ex_wr && (ex_dst != '0) &&
                       ((id_use_rs && id_rs == ex_dst) || (id_use_rt && id_rt == ex_dst));
    assign mem_touch = mem_wr && (mem_dst != '0) &&
                       ((id_use_rs && id_rs == mem_dst) || (id_use_rt && id_rt == mem_dst));

    assign lu_hit     = ex_touch && ex_load;
    assign br_ex_hit  = id_branch && ex_touch;
    assign br_mem_hit = id_branch && mem_touch && mem_load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // Transitions and outputs
    always_comb begin
        stall_o  = lu_hit || br_ex_hit || br_mem_hit;
        bubble_o = stall_o;
        state_d  = S_RUN;
        unique case (state_q)
            S_RUN, S_LU_HOLD, S_BR_HOLD: begin
                if (lu_hit)                       state_d = S_LU_HOLD; // T_TO_LU
                else if (br_ex_hit || br_mem_hit) state_d = S_BR_HOLD; // T_TO_BR
                else                              state_d = S_RUN;     // T_TO_RUN
            end
            default: state_d = S_RUN;
        endcase
    end

    // R6
    lu_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LU_HOLD) |-> !lu_hit);

    // R5
    r0_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !id_branch) |-> (ex_dst != '0));

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_wr,
    input  logic             id_load,
    input  logic             id_branch,
    output logic             stall_o,
    output logic             bubble_o,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b,
    output logic [1:0]       id_fwd_a,
    output logic [1:0]       id_fwd_b
);

    localparam int N_OPS = 4;

    logic [REG_W-1:0] ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
    logic             ex_use_rs, ex_use_rt, ex_wr, ex_load;
    logic             mem_wr, mem_load, wb_wr;

    hz_stage_track #(.REG_W(REG_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (stall_o),
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .id_use_rs (id_use_rs),
        .id_use_rt (id_use_rt),
        .id_dst    (id_dst),
        .id_wr     (id_wr),
        .id_load   (id_load),
        .ex_rs     (ex_rs),
        .ex_rt     (ex_rt),
        .ex_use_rs (ex_use_rs),
        .ex_use_rt (ex_use_rt),
        .ex_dst    (ex_dst),
        .ex_wr     (ex_wr),
        .ex_load   (ex_load),
        .mem_dst   (mem_dst),
        .mem_wr    (mem_wr),
        .mem_load  (mem_load),
        .wb_dst    (wb_dst),
        .wb_wr     (wb_wr)
    );

    hz_interlock #(.REG_W(REG_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .id_use_rs (id_use_rs),
        .id_use_rt (id_use_rt),
        .id_branch (id_branch),
        .ex_dst    (ex_dst),
        .ex_wr     (ex_wr),
        .ex_load   (ex_load),
        .mem_dst   (mem_dst),
        .mem_wr    (mem_wr),
        .mem_load  (mem_load),
        .stall_o   (stall_o),
        .bubble_o  (bubble_o)
    );

    // Operand list: 0/1 execute ALU operands, 2/3 decode branch operands
    logic [REG_W-1:0] op_src  [N_OPS];
    logic             op_used [N_OPS];
    logic [1:0]       op_sel  [N_OPS];

    assign op_src[0]  = ex_rs;
    assign op_src[1]  = ex_rt;
    assign op_src[2]  = id_rs;
    assign op_src[3]  = id_rt;
    assign op_used[0] = ex_use_rs;
    assign op_used[1] = ex_use_rt;
    assign op_used[2] = id_use_rs && id_branch;
    assign op_used[3] = id_use_rt && id_branch;

    for (genvar g = 0; g < N_OPS; g++) begin : g_pick
        hz_fwd_pick #(.REG_W(REG_W)) u_pick (
            .src     (op_src[g]),
            .used    (op_used[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (op_sel[g])
        );
    end

    assign ex_fwd_a = op_sel[0];
    assign ex_fwd_b = op_sel[1];
    assign id_fwd_a = op_sel[2];
    assign id_fwd_b = op_sel[3];

    // R2
    no_load_mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_fwd_a == FWD_MEM || ex_fwd_b == FWD_MEM) |-> !mem_load);

    // R5
    r0_never_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_fwd_a != FWD_NONE) |-> (ex_rs != '0)) and
        ((ex_fwd_b != FWD_NONE) |-> (ex_rt != '0)));

    // R13
    id_sel_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_branch |-> (id_fwd_a == FWD_NONE && id_fwd_b == FWD_NONE));

    // R8
    bubble_never_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ##1 (!mem_wr));

endmodule

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;

    localparam int MAXP = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs = '0, id_rt = '0, id_dst = '0;
    logic       id_use_rs = 1'b0, id_use_rt = 1'b0, id_wr = 1'b0, id_load = 1'b0, id_branch = 1'b0;
    logic       stall_o, bubble_o;
    logic [1:0] ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b;

    always #5 clk = ~clk;

    pipe_hazard_ctl u_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .id_dst(id_dst), .id_wr(id_wr), .id_load(id_load), .id_branch(id_branch),
        .stall_o(stall_o), .bubble_o(bubble_o),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Program storage
    int p_rs[MAXP], p_rt[MAXP], p_dst[MAXP];
    bit p_urs[MAXP], p_urt[MAXP], p_wr[MAXP], p_ld[MAXP], p_br[MAXP];
    int n = 0;

    task automatic add_insn(int rs, int rt, bit urs, bit urt, int dst, bit wr, bit ld, bit br);
        p_rs[n] = rs; p_rt[n] = rt; p_urs[n] = urs; p_urt[n] = urt;
        p_dst[n] = dst; p_wr[n] = wr; p_ld[n] = ld; p_br[n] = br;
        n++;
    endtask

    function automatic bit ok(int i); return (i >= 0 && i < n); endfunction
    function automatic int  g_rs(int i);  return ok(i) ? p_rs[i]  : 0; endfunction
    function automatic int  g_rt(int i);  return ok(i) ? p_rt[i]  : 0; endfunction
    function automatic int  g_dst(int i); return ok(i) ? p_dst[i] : 0; endfunction
    function automatic bit  g_urs(int i); return ok(i) ? p_urs[i] : 0; endfunction
    function automatic bit  g_urt(int i); return ok(i) ? p_urt[i] : 0; endfunction
    function automatic bit  g_wr(int i);  return ok(i) ? p_wr[i]  : 0; endfunction
    function automatic bit  g_ld(int i);  return ok(i) ? p_ld[i]  : 0; endfunction
    function automatic bit  g_br(int i);  return ok(i) ? p_br[i]  : 0; endfunction

    // Does a source read the result of instruction j?
    function automatic bit reads(int src, bit used, int j);
        return used && src != 0 && g_wr(j) && g_dst(j) == src;
    endfunction

    function automatic int pick(int src, bit used, int mj, int wj);
        if (reads(src, used, mj)) return 2;
        if (reads(src, used, wj)) return 1;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Pipe model: instruction indices, -1 empty, -2 bubble
    int d = 0, ex_i = -1, mem_i = -1, wb_i = -1;
    bit prev_br = 0;

    initial begin
        // Directed stream
        add_insn(2, 3, 1, 1, 1, 1, 0, 0);   // r1 <- r2,r3
        add_insn(1, 0, 1, 1, 4, 1, 0, 0);   // uses r1 (MEM), r0
        add_insn(3, 1, 1, 1, 5, 1, 0, 0);   // uses r1 (WB)
        add_insn(2, 2, 1, 1, 6, 1, 0, 0);   // r6
        add_insn(3, 3, 1, 1, 6, 1, 0, 0);   // r6 again
        add_insn(6, 6, 1, 1, 7, 1, 0, 0);   // both stages hit r6
        add_insn(0, 0, 1, 0, 8, 1, 1, 0);   // load r8
        add_insn(8, 2, 1, 1, 9, 1, 0, 0);   // load-use
        add_insn(0, 0, 1, 0, 10, 1, 1, 0);  // load r10
        add_insn(3, 2, 1, 1, 11, 1, 0, 0);  // independent
        add_insn(2, 3, 1, 1, 13, 1, 0, 0);  // r13
        add_insn(13, 1, 1, 1, 0, 0, 0, 1);  // branch on r13
        add_insn(2, 3, 1, 1, 14, 1, 0, 0);  // delay slot
        add_insn(0, 0, 1, 0, 15, 1, 1, 0);  // load r15
        add_insn(15, 0, 1, 1, 0, 0, 0, 1);  // branch on loaded r15
        add_insn(3, 3, 1, 1, 16, 1, 0, 0);  // delay slot
        add_insn(2, 3, 1, 1, 0, 1, 0, 0);   // writes r0
        add_insn(0, 0, 1, 1, 17, 1, 0, 0);  // reads r0
        add_insn(0, 0, 1, 0, 0, 1, 1, 0);   // load r0
        add_insn(0, 2, 1, 1, 18, 1, 0, 0);  // reads r0
        add_insn(2, 3, 1, 1, 19, 1, 0, 0);  // r19
        add_insn(19, 3, 1, 1, 20, 1, 0, 0); // ALU dep, no stall
        add_insn(0, 0, 0, 0, 0, 0, 0, 0);   // NOP
        // Random stream over a narrow register set
        for (int k = 0; k < 300; k++) begin
            int kind = int'($urandom_range(0, 7));
            int a = int'($urandom_range(0, 3));
            int b = int'($urandom_range(0, 3));
            int c = int'($urandom_range(0, 3));
            if (kind < 2)      add_insn(a, 0, 1, 0, c, 1, 1, 0);
            else if (kind < 4) add_insn(a, b, 1, 1, 0, 0, 0, 1);
            else if (kind < 7) add_insn(a, b, 1, 1, c, 1, 0, 0);
            else               add_insn(0, 0, 0, 0, 0, 0, 0, 0);
        end

        repeat (2) @(negedge clk);
        #2;
        chk("R1", stall_o, 0, "stall after reset");
        chk("R1", bubble_o, 0, "bubble after reset");
        chk("R1", ex_fwd_a, 0, "ex_fwd_a after reset");
        chk("R1", id_fwd_a, 0, "id_fwd_a after reset");
        rst_n = 1'b1;

        while (d < n + 4) begin
            bit lu, bex, bmem, stl;
            int ea, eb, ia, ib;
            string ts, tfa, tfb;
            @(negedge clk);
            id_rs = 5'(g_rs(d)); id_rt = 5'(g_rt(d));
            id_use_rs = g_urs(d); id_use_rt = g_urt(d);
            id_dst = 5'(g_dst(d)); id_wr = g_wr(d); id_load = g_ld(d); id_branch = g_br(d);
            #2;
            lu   = g_ld(ex_i) && (reads(g_rs(d), g_urs(d), ex_i) || reads(g_rt(d), g_urt(d), ex_i));
            bex  = g_br(d) && (reads(g_rs(d), g_urs(d), ex_i) || reads(g_rt(d), g_urt(d), ex_i));
            bmem = g_br(d) && g_ld(mem_i) &&
                   (reads(g_rs(d), g_urs(d), mem_i) || reads(g_rt(d), g_urt(d), mem_i));
            stl  = lu || bex || bmem;
            ea = pick(g_rs(ex_i), g_urs(ex_i), mem_i, wb_i);
            eb = pick(g_rt(ex_i), g_urt(ex_i), mem_i, wb_i);
            ia = pick(g_rs(d), g_urs(d) && g_br(d), mem_i, wb_i);
            ib = pick(g_rt(d), g_urt(d) && g_br(d), mem_i, wb_i);

            if (lu)        ts = "R6";
            else if (bmem) ts = "R10";
            else if (bex)  ts = "R9";
            else if (prev_br) ts = "R11";
            else if (reads(g_rs(d), g_urs(d), ex_i) || reads(g_rt(d), g_urt(d), ex_i)) ts = "R12";
            else           ts = "R7";
            chk(ts, stall_o, stl, "stall");
            chk(ts, bubble_o, stl, "bubble");

            if (mem_i == -2 || wb_i == -2) tfa = "R8";
            else if (ea == 2 && reads(g_rs(ex_i), g_urs(ex_i), wb_i)) tfa = "R4";
            else if (ea == 2) tfa = "R2";
            else if (ea == 1) tfa = "R3";
            else if (g_rs(ex_i) == 0) tfa = "R5";
            else tfa = "R3";
            tfb = (g_rt(ex_i) == 0 && eb == 0) ? "R5" : tfa;
            chk(tfa, ex_fwd_a, ea, "ex_fwd_a");
            chk(tfb, ex_fwd_b, eb, "ex_fwd_b");
            chk(g_br(d) ? (ia == 1 ? "R10" : "R9") : "R13", id_fwd_a, ia, "id_fwd_a");
            chk(g_br(d) ? (ib == 1 ? "R10" : "R9") : "R13", id_fwd_b, ib, "id_fwd_b");

            // Advance the model to the next edge
            wb_i = mem_i; mem_i = ex_i;
            if (stl) ex_i = -2;
            else begin
                ex_i = d; prev_br = g_br(d); d++;
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule